// File: doc/BRIEF.md
# Reed-Solomon Parity Re-Encoder

This block is the front stage of a double-error-correcting Reed-Solomon decoder for 63-symbol words over GF(2^6). Received symbols stream in one per accepted beat, highest-degree coefficient first, and the first symbol of every word is flagged by a start marker. The 59 information symbols pass through a systematic polynomial divider that regenerates the four check symbols an encoder would have produced. As each of the four received check symbols arrives, it is XORed with its regenerated counterpart.

The four differences form a parity-check vector. Coefficient j of this vector is tied to the field location alpha^j. The vector is presented with a one-cycle valid pulse together with a flag that is set when every entry is zero, which means no error was detected. A key-equation solver downstream consumes the vector. That solver, the root search and the buffer for the received word all live outside this block.

Top module: `rs_parity_reencoder`

## Requirements
- R1: The field is GF(2^6) built on x^6+x+1, with alpha = 6'h02. The generator is g(x) = x^4 + 6'h0F x^3 + 6'h36 x^2 + 6'h3B x + 6'h03, whose roots are alpha^0..alpha^3. A word that is a valid codeword gives chk_word = 0.
- R2: The first accepted symbol of a word (in_sof=1) is the coefficient of x^62 and the 63rd is the coefficient of x^0. chk_word[6j+5:6j] equals coefficient j of (received word mod g(x)), which is the regenerated check symbol j XOR the received coefficient of x^j.
- R3: An error value e in the received check position of degree j changes only chk_word[6j+5:6j], which becomes e.
- R4: out_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the 63rd symbol.
- R5: chk_word and out_clean hold their values between completions. Cycles with in_valid=0 accept nothing and do not alter the result.
- R6: in_valid=1 with in_sof=1 in the middle of a word discards the partial word and starts a new one with this symbol as its x^62 coefficient.
- R7: Symbols with in_valid=1 and in_sof=0 that arrive after a word has completed and before the next start marker are ignored.
- R8: out_clean is 1 exactly when the chk_word delivered with the latest out_valid is all zero. It updates together with chk_word.
- R9: After reset, out_valid=0, chk_word=0 and out_clean=0.
- R10: A start marker accepted in the cycle right after a word's last symbol is handled with no lost cycle. Both words produce correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Symbol on in_sym is presented this cycle |
| in_sof | input | 1 | Marks the first symbol of a word (qualified by in_valid) |
| in_sym | input | 6 | Received symbol |
| out_valid | output | 1 | One-cycle pulse when a new parity-check vector is available |
| chk_word | output | 24 | Parity-check vector, entry j in bits [6j+5:6j] |
| out_clean | output | 1 | Set when the latest vector is all zero |

## Verification
Two things can coincide in one cycle. One is the completion of a word: the result registers load and out_valid pulses. The other is the start marker of the following word, which clears the divider while it takes in that word's first symbol. The bench sends two words back to back with no idle beat between them. It samples the first word's vector in the cycle that the second word's start symbol is being driven, then checks the second word's vector against an independent model. That model reduces the full received polynomial modulo g(x) using precomputed x^k mod g(x) terms. A mid-word restart and ignored symbols after completion are also checked, to show the divider state never leaks across a word boundary.

// File: rtl/rsre_pkg.sv
`timescale 1ns/1ps
package rsre_pkg;
  localparam int SYM_W = 6;
  localparam logic [SYM_W:0] FIELD_POLY = 7'b1000011;
  localparam int MAX_CHK = 8;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [MAX_CHK:0] gpoly_t;

  // multiply by alpha, reduce by the field polynomial
  function automatic sym_t gf_xtime(sym_t a);
    logic [SYM_W:0] t;
    t = {a, 1'b0};
    if (t[SYM_W]) t = t ^ FIELD_POLY;
    return t[SYM_W-1:0];
  endfunction

  // shift-and-add field multiply
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t v;
    v = sym_t'(1);
    for (int i = 0; i < e; i++) v = gf_xtime(v);
    return v;
  endfunction

  // product of (x + alpha^i) for i = 0 .. nchk-1, coefficient k at index k
  function automatic gpoly_t gen_poly(int nchk);
    gpoly_t c;
    sym_t   root;
    c    = '0;
    c[0] = sym_t'(1);
    for (int i = 0; i < nchk; i++) begin
      root = gf_alpha_pow(i);
      for (int k = MAX_CHK; k > 0; k--) c[k] = c[k-1] ^ gf_mul(c[k], root);
      c[0] = gf_mul(c[0], root);
    end
    return c;
  endfunction
endpackage

// File: rtl/rsre_ctrl.sv
`timescale 1ns/1ps
module rsre_ctrl #(
  parameter int NUM_INFO = 59,
  parameter int NUM_CHK  = 4,
  parameter int POS_W    = 6,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic             info_beat,
  output logic             chk_beat,
  output logic             last_beat,
  output logic [IDX_W-1:0] chk_idx,
  output logic             busy,
  output logic [POS_W-1:0] pos
);
  localparam int WORD_LEN = NUM_INFO + NUM_CHK;

  logic [POS_W-1:0] pos_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      busy_q <= 1'b0;
    end else if (in_valid && in_sof) begin
      pos_q  <= POS_W'(1);
      busy_q <= 1'b1;
    end else if (in_valid && busy_q) begin
      if (pos_q == POS_W'(WORD_LEN - 1)) begin
        pos_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign info_beat = in_valid & (in_sof | (busy_q & (pos_q < POS_W'(NUM_INFO))));
  assign chk_beat  = in_valid & ~in_sof & busy_q & (pos_q >= POS_W'(NUM_INFO));
  assign last_beat = chk_beat & (pos_q == POS_W'(WORD_LEN - 1));
  // check symbols arrive highest degree first: degree = WORD_LEN-1-pos
  assign chk_idx   = IDX_W'(POS_W'(WORD_LEN - 1) - pos_q);
  assign busy      = busy_q;
  assign pos       = pos_q;
endmodule

// File: rtl/rsre_div_stage.sv
`timescale 1ns/1ps
module rsre_div_stage
  import rsre_pkg::*;
#(
  parameter logic [rsre_pkg::SYM_W-1:0] COEF = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic info_beat,
  input  logic chk_beat,
  input  sym_t fb,
  input  sym_t prev_in,
  output sym_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (info_beat) q <= prev_in ^ gf_mul(fb, COEF);
    else if (chk_beat)  q <= prev_in;   // plain shift toward the top stage
  end
endmodule

// File: rtl/rsre_collect.sv
`timescale 1ns/1ps
module rsre_collect
  import rsre_pkg::*;
#(
  parameter int NUM_CHK = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chk_beat,
  input  logic                     last_beat,
  input  logic [IDX_W-1:0]         chk_idx,
  input  sym_t                     chk_diff,
  output logic                     out_valid,
  output logic [NUM_CHK*SYM_W-1:0] chk_word,
  output logic                     out_clean
);
  sym_t                     stage_q [NUM_CHK];
  logic [NUM_CHK*SYM_W-1:0] nxt_word;

  for (genvar j = 0; j < NUM_CHK; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      stage_q[j] <= '0;
      else if (chk_beat && (chk_idx == IDX_W'(j)))     stage_q[j] <= chk_diff;
    end
    assign nxt_word[j*SYM_W +: SYM_W] =
      (last_beat && (chk_idx == IDX_W'(j))) ? chk_diff : stage_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      chk_word  <= '0;
      out_clean <= 1'b0;
    end else begin
      out_valid <= last_beat;
      if (last_beat) begin
        chk_word  <= nxt_word;
        out_clean <= (nxt_word == '0);
      end
    end
  end
endmodule

// File: rtl/rs_parity_reencoder.sv
`timescale 1ns/1ps
module rs_parity_reencoder
  import rsre_pkg::*;
#(
  parameter int NUM_INFO = 59,
  parameter int NUM_CHK  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               in_sof,
  input  logic [rsre_pkg::SYM_W-1:0]         in_sym,
  output logic                               out_valid,
  output logic [NUM_CHK*rsre_pkg::SYM_W-1:0] chk_word,
  output logic                               out_clean
);
  localparam int     WORD_LEN = NUM_INFO + NUM_CHK;
  localparam int     POS_W    = $clog2(WORD_LEN + 1);
  localparam int     IDX_W    = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1;
  localparam gpoly_t GEN      = gen_poly(NUM_CHK);

  // internal events, named for the checker
  logic             info_beat;
  logic             chk_beat;
  logic             last_beat;
  logic [IDX_W-1:0] chk_idx;
  logic             busy_w;
  logic [POS_W-1:0] pos_w;
  sym_t             fb;
  sym_t             chk_diff;

  sym_t st     [NUM_CHK];
  sym_t st_eff [NUM_CHK];
  sym_t prev_v [NUM_CHK];

  rsre_ctrl #(
    .NUM_INFO(NUM_INFO), .NUM_CHK(NUM_CHK), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .info_beat(info_beat), .chk_beat(chk_beat), .last_beat(last_beat),
    .chk_idx(chk_idx), .busy(busy_w), .pos(pos_w)
  );

  // a start marker makes the divider see an all-zero state
  for (genvar j = 0; j < NUM_CHK; j++) begin : g_stage
    assign st_eff[j] = in_sof ? '0 : st[j];
    if (j == 0) begin : g_first
      assign prev_v[j] = '0;
    end else begin : g_rest
      assign prev_v[j] = st_eff[j-1];
    end
    rsre_div_stage #(.COEF(GEN[j])) u_stage (
      .clk(clk), .rst_n(rst_n), .info_beat(info_beat), .chk_beat(chk_beat),
      .fb(fb), .prev_in(prev_v[j]), .q(st[j])
    );
  end

  assign fb       = in_sym ^ st_eff[NUM_CHK-1];
  assign chk_diff = fb;   // during check beats: regenerated XOR received

  rsre_collect #(.NUM_CHK(NUM_CHK), .IDX_W(IDX_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .chk_beat(chk_beat), .last_beat(last_beat),
    .chk_idx(chk_idx), .chk_diff(chk_diff),
    .out_valid(out_valid), .chk_word(chk_word), .out_clean(out_clean)
  );
endmodule

// File: rtl/rs_parity_reencoder_chk.sv
`timescale 1ns/1ps
module rs_parity_reencoder_chk #(
  parameter int W     = 24,
  parameter int POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             out_valid,
  input logic [W-1:0]     chk_word,
  input logic             out_clean,
  input logic             last_beat,
  input logic             busy,
  input logic [POS_W-1:0] pos
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_pulse_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last_beat));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(chk_word) && $stable(out_clean)));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pos) && $stable(busy)));

  assert_clean_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_clean == (chk_word == '0)));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (busy && (pos == POS_W'(1))));

  assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !busy) |=> (!busy && !out_valid));
endmodule

bind rs_parity_reencoder rs_parity_reencoder_chk #(
  .W(NUM_CHK * rsre_pkg::SYM_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .chk_word(chk_word), .out_clean(out_clean),
  .last_beat(last_beat), .busy(busy_w), .pos(pos_w)
);

// File: tb/rs_parity_reencoder_bench.sv
`timescale 1ns/1ps
module rs_parity_reencoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [5:0]  in_sym = '0;
  logic        out_valid;
  logic [23:0] chk_word;
  logic        out_clean;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  rs_parity_reencoder u_rs_parity_reencoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_sym(in_sym), .out_valid(out_valid), .chk_word(chk_word),
    .out_clean(out_clean)
  );

  // R1 generator coefficients
  localparam logic [5:0] G3 = 6'h0F, G2 = 6'h36, G1 = 6'h3B, G0 = 6'h03;

  logic [5:0] expt [63];
  int         lg   [64];
  logic [5:0] xp   [63][4];   // x^k mod g(x), coefficient j
  logic [5:0] tx   [63];      // beat p carries degree 62-p
  logic [5:0] ta   [63];

  function automatic logic [5:0] gm(logic [5:0] a, logic [5:0] b);
    if (a == 0 || b == 0) return 6'h00;
    return expt[(lg[a] + lg[b]) % 63];
  endfunction

  task automatic build_tables();
    logic [5:0] v;
    logic [5:0] t;
    v = 6'h01;
    for (int e = 0; e < 63; e++) begin
      expt[e] = v;
      lg[v]   = e;
      v = {v[4:0], 1'b0} ^ (v[5] ? 6'h03 : 6'h00);
    end
    xp[0][0] = 6'h01; xp[0][1] = 0; xp[0][2] = 0; xp[0][3] = 0;
    for (int k = 1; k < 63; k++) begin
      t = xp[k-1][3];
      xp[k][3] = xp[k-1][2] ^ gm(t, G3);
      xp[k][2] = xp[k-1][1] ^ gm(t, G2);
      xp[k][1] = xp[k-1][0] ^ gm(t, G1);
      xp[k][0] = gm(t, G0);
    end
  endtask

  function automatic logic [23:0] model();
    logic [5:0] r [4];
    for (int j = 0; j < 4; j++) r[j] = 0;
    for (int p = 0; p < 63; p++)
      for (int j = 0; j < 4; j++) r[j] ^= gm(tx[p], xp[62-p][j]);
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic fill(int seed);
    for (int p = 0; p < 63; p++) tx[p] = 6'((seed * 11 + p * 13 + p * p * 5 + seed * p) & 63);
  endtask

  task automatic make_codeword();
    logic [23:0] r;
    for (int p = 59; p < 63; p++) tx[p] = 0;
    r = model();
    for (int j = 0; j < 4; j++) tx[62-j] = r[6*j +: 6];
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] s, bit sof);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_sym = s;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // sends tx; returns at the negedge where the result pulse is visible
  task automatic send_word(bit gaps);
    for (int p = 0; p < 63; p++) begin
      if (gaps && (p % 5 == 2)) begin idle(); idle(); end
      drive(tx[p], p == 0);
    end
    idle();
  endtask

  task automatic expect_result(string req, logic [23:0] exp);
    check("R4", {req, " out_valid pulse"}, 32'(out_valid), 1);
    check(req, "chk_word", 32'(chk_word), 32'(exp));
    check("R8", {req, " out_clean"}, 32'(out_clean), 32'(exp == 0));
    idle();
    check("R4", {req, " pulse ends"}, 32'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R9", "out_valid after reset", 32'(out_valid), 0);
    check("R9", "chk_word after reset", 32'(chk_word), 0);
    check("R9", "out_clean after reset", 32'(out_clean), 0);
  endtask

  task automatic t_clean();
    fill(3); make_codeword();
    send_word(1'b0);
    expect_result("R1", 24'h0);
  endtask

  task automatic t_info_errors();
    logic [23:0] e;
    fill(9); make_codeword();
    tx[5] ^= 6'h21; tx[40] ^= 6'h07;
    e = model();
    send_word(1'b0);
    check("R2", "two info errors nonzero", 32'(e != 0), 1);
    expect_result("R2", e);
    fill(21);
    e = model();
    send_word(1'b0);
    expect_result("R2", e);
  endtask

  task automatic t_check_err();
    for (int j = 0; j < 4; j++) begin
      logic [5:0] ev;
      ev = 6'(6'h11 + j * 9);
      fill(30 + j); make_codeword();
      tx[62-j] ^= ev;
      send_word(1'b0);
      expect_result("R3", 24'(ev) << (6 * j));
    end
  endtask

  task automatic t_gaps();
    logic [23:0] e;
    fill(44); make_codeword(); tx[17] ^= 6'h2A;
    e = model();
    send_word(1'b1);
    check("R5", "result with stalls", 32'(chk_word), 32'(e));
    repeat (10) idle();
    check("R5", "result held", 32'(chk_word), 32'(e));
    check("R5", "no extra pulse", 32'(out_valid), 0);
  endtask

  task automatic t_restart();
    fill(50);
    for (int p = 0; p < 30; p++) drive(tx[p] ^ 6'h15, p == 0);
    fill(51); make_codeword();
    send_word(1'b0);
    expect_result("R6", 24'h0);
  endtask

  task automatic t_idle_junk();
    logic [23:0] held;
    logic [23:0] e;
    held = chk_word;
    for (int p = 0; p < 70; p++) drive(6'(p * 7 + 1), 1'b0);
    idle();
    check("R7", "no pulse from junk", 32'(out_valid), 0);
    check("R7", "result kept", 32'(chk_word), 32'(held));
    fill(60); make_codeword(); tx[61] ^= 6'h3C;
    e = model();
    send_word(1'b0);
    expect_result("R7", e);
  endtask

  task automatic t_back2back();
    logic [23:0] ea;
    logic [23:0] eb;
    fill(70); make_codeword(); tx[0] ^= 6'h01; tx[60] ^= 6'h30;
    ea = model();
    for (int p = 0; p < 63; p++) ta[p] = tx[p];
    fill(71); make_codeword(); tx[33] ^= 6'h0B;
    eb = model();
    for (int p = 0; p < 63; p++) drive(ta[p], p == 0);
    @(negedge clk);
    check("R10", "first pulse", 32'(out_valid), 1);
    check("R10", "first word result", 32'(chk_word), 32'(ea));
    in_valid = 1'b1; in_sof = 1'b1; in_sym = tx[0];
    for (int p = 1; p < 63; p++) drive(tx[p], 1'b0);
    idle();
    check("R10", "second pulse", 32'(out_valid), 1);
    check("R10", "second word result", 32'(chk_word), 32'(eb));
    idle();
  endtask

  initial begin
    build_tables();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_clean();
    t_info_errors();
    t_check_err();
    t_gaps();
    t_restart();
    t_idle_junk();
    t_back2back();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule